// File: doc/BRIEF.md
# Flow-Gated Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte is written into a one-entry holding buffer with a load strobe. When the transmitter is enabled and the clear-to-send input (active low) is asserted, the byte moves into a shift register on the next falling edge of an external transmit clock. The frame is then sent at one bit per transmit-clock period, with no oversampling: a low start bit, the data bits least-significant first, an optional parity bit, and one or two high stop bits.

All logic runs on a system clock. The transmit clock and the clear-to-send input pass through a synchronizer, and the falling edge of the transmit clock is detected from the synchronized copy. The line changes only in the system cycle after such an edge. Two status flags report progress, and they change at different points of a frame. `tx_empty` reports that the holding buffer can accept a byte, and it rises as soon as a start bit begins. `tx_ready` reports that the whole transmitter is quiet, and it rises only after the last stop bit of the last frame has been sent.

A byte written while a frame is on the line waits in the holding buffer. If the gating conditions still hold, it starts on the same falling edge that ends the current frame's last stop bit, so no idle bit appears between the two frames.

Top module: `serial_tx_flow`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is high, and both `tx_empty` and `tx_ready` are 1 when nothing is pending.
- R2: A frame is a low start bit followed by the data bits least-significant first. The data width is `DATA_W-3+cfg_len` bits, so with DATA_W=8 the codes 0,1,2,3 select 5,6,7,8 bits.
- R3: When `cfg_par_en`=1, one parity bit follows the last data bit. With `cfg_par_odd`=0, the data bits plus the parity bit hold an even number of ones; with `cfg_par_odd`=1 they hold an odd number.
- R4: The frame ends with high stop bits: two when `cfg_two_stop`=1, one when it is 0. Eight data bits with no parity and two stop bits therefore take ten transmit-clock periods after the start bit.
- R5: `txd` changes only in the system cycle after a detected falling edge of `txc`, so each bit lasts one full transmit-clock period.
- R6: While `cts_n` is high, a pending byte is held and `txd` stays high. After `cts_n` goes low, the start bit begins on the next falling edge of `txc`.
- R7: While `tx_en` is 0, a pending byte is not started. It starts on a falling edge after `tx_en` returns to 1.
- R8: `tx_empty` falls when a byte is loaded into the free buffer. It rises in the cycle in which that byte's start bit begins.
- R9: `tx_ready` is 0 while a byte is pending or a frame is in progress. It returns to 1 only after the final stop bit has been sent.
- R10: A load strobe that arrives while the holding buffer is occupied is ignored. The byte already held is the one transmitted.
- R11: A byte that is pending at the end of a frame starts on the falling edge that ends the last stop bit, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txc | input | 1 | External transmit clock, one bit per period |
| cts_n | input | 1 | Clear-to-send, active low |
| tx_en | input | 1 | Transmitter enable |
| load | input | 1 | One-cycle strobe that writes `load_data` into the holding buffer |
| load_data | input | DATA_W | Byte to transmit |
| cfg_len | input | 2 | Data length code: `DATA_W-3+cfg_len` bits |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1, one when 0 |
| txd | output | 1 | Serial data line, idles high |
| tx_empty | output | 1 | Holding buffer is free |
| tx_ready | output | 1 | No byte pending and no frame in progress |

## Verification
The bench uses the default parameters: DATA_W=8 and a two-stage synchronizer. With these values, the length code covers every width from five to eight data bits, and every parity and stop-bit combination can be driven from the ports. The transmit clock runs at sixteen system cycles per period. The synchronizer delay of a few cycles therefore stays well inside each bit, so the line can be sampled on every rising transmit-clock edge. This lets the bench check clear-to-send holds, enable holds, loads into an occupied buffer, and frames sent back to back with no gap.

// File: rtl/atx_pkg.sv
// Shared types for the serial transmitter.
// Assumes the data length code is two bits wide.
package atx_pkg;

    // Frame configuration captured together with the byte at frame start.
    typedef struct packed {
        logic [1:0] len;       // data bits = DATA_W - 3 + len
        logic       par_en;    // insert a parity bit
        logic       par_odd;   // 1: odd parity, 0: even parity
        logic       two_stop;  // 1: two stop bits, 0: one stop bit
    } frame_cfg_t;

endpackage

// File: rtl/stx_sync_edge.sv
// Synchronizes the transmit clock and clear-to-send into the system clock
// domain, and produces a one-cycle pulse on each falling edge of the
// synchronized transmit clock.
// Assumes the transmit clock is much slower than clk (several clk cycles
// per half period) and that STAGES >= 1.
module stx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txc,
    input  logic cts_n,
    output logic txc_fall,
    output logic cts_ok
);

    logic [STAGES-1:0] txc_q;
    logic [STAGES-1:0] cts_q;
    logic              txc_prev;

    // Shift both asynchronous inputs through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txc_q <= '0;
            cts_q <= '1;
        end else begin
            txc_q <= STAGES'({txc_q, txc});
            cts_q <= STAGES'({cts_q, cts_n});
        end
    end

    // Keep the previous synchronized transmit clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txc_prev <= 1'b0;
        end else begin
            txc_prev <= txc_q[STAGES-1];
        end
    end

    // Falling edge pulse and active-high clear-to-send.
    always_comb begin
        txc_fall = txc_prev & ~txc_q[STAGES-1];
        cts_ok   = ~cts_q[STAGES-1];
    end

endmodule

// File: rtl/stx_hold_buf.sv
// One-entry transmit holding buffer.
// A load is accepted only when the buffer is free. A take empties it.
// Assumes take is asserted only while the buffer is full.
module stx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Track occupancy and capture the byte on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (load && !full) begin
            full <= 1'b1;
            data <= load_data;
        end
    end

    // R10: a load into an occupied buffer must not change the held byte.
    assert_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load && !take) |=> $stable(data));

endmodule

// File: rtl/stx_frame_build.sv
// Combinational frame assembly. The result is bit 0 = start bit, then the
// data bits LSB first, an optional parity bit, and high stop bits. Unused
// upper positions are high. nbits is the total number of bit times.
// Assumes FRAME_W = DATA_W + 4 and DATA_W >= 4.
module stx_frame_build
    import atx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  frame_cfg_t         cfg,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);

    int   ndata;
    logic par;

    // Lay out the start, data, parity and stop bits for the current byte.
    always_comb begin
        ndata = DATA_W - 3 + int'(cfg.len);
        frame = '1;
        frame[0] = 1'b0;
        par = cfg.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < ndata) begin
                frame[i+1] = data[i];
                par = par ^ data[i];
            end
        end
        if (cfg.par_en) begin
            for (int j = 1; j < FRAME_W; j++) begin
                if (j == ndata + 1) begin
                    frame[j] = par;
                end
            end
        end
        nbits = CNT_W'(2 + ndata + int'(cfg.par_en) + int'(cfg.two_stop));
    end

endmodule

// File: rtl/stx_shifter.sv
// Bit serializer. On each transmit-clock falling pulse, it either starts a
// new frame (when the previous frame has finished and a start is allowed)
// or moves to the next bit. The line is registered and idles high.
// Assumes nbits >= 2 whenever a start is requested.
module stx_shifter #(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall_p,
    input  logic               can_start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    output logic               take,
    output logic               busy,
    output logic               txd
);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   remain;
    logic               last;

    // Decide whether this falling edge begins a new frame.
    always_comb begin
        last = (remain == '0);
        take = fall_p && can_start && (!busy || last);
    end

    // Start a frame, shift out the next bit, or return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            remain <= '0;
            busy   <= 1'b0;
            txd    <= 1'b1;
        end else if (fall_p) begin
            if (take) begin
                shreg  <= {1'b1, frame[FRAME_W-1:1]};
                remain <= nbits - CNT_W'(1);
                busy   <= 1'b1;
                txd    <= frame[0];
            end else if (busy) begin
                if (!last) begin
                    txd    <= shreg[0];
                    shreg  <= {1'b1, shreg[FRAME_W-1:1]};
                    remain <= remain - CNT_W'(1);
                end else begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end
            end
        end
    end

    // R1: the line rests at mark whenever no frame is in progress.
    assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R5: the line moves only right after a transmit-clock falling edge.
    assert_bit_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(fall_p));

endmodule

// File: rtl/serial_tx_flow.sv
// Asynchronous serial transmitter with clear-to-send gating.
// It connects the synchronizer/edge detector, the holding buffer, the frame
// builder and the shifter. It assumes txc runs far slower than clk. The
// frame configuration must stay stable while a byte waits to start.
module serial_tx_flow
    import atx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txc,
    input  logic              cts_n,
    input  logic              tx_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_ready
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               fall_p;
    logic               cts_ok;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               take;
    logic               busy;
    logic               can_start;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    frame_cfg_t         cfg;

    // Pack the configuration pins and form the start condition and flags.
    always_comb begin
        cfg       = '{len: cfg_len, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};
        can_start = hold_full && tx_en && cts_ok;
        tx_empty  = !hold_full;
        tx_ready  = !hold_full && !busy;
    end

    stx_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .txc      (txc),
        .cts_n    (cts_n),
        .txc_fall (fall_p),
        .cts_ok   (cts_ok)
    );

    stx_hold_buf #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .take      (take),
        .full      (hold_full),
        .data      (hold_data)
    );

    stx_frame_build #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_build (
        .data  (hold_data),
        .cfg   (cfg),
        .frame (frame),
        .nbits (nbits)
    );

    stx_shifter #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_p    (fall_p),
        .can_start (can_start),
        .frame     (frame),
        .nbits     (nbits),
        .take      (take),
        .busy      (busy),
        .txd       (txd)
    );

    // R6 and R7: a frame may begin only with clear-to-send, enable and a byte.
    assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cts_ok && tx_en && hold_full));

    // R8: the buffer becomes free only as a start bit goes out.
    assert_empty_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> (busy && $past(fall_p)));

    // R9: ready returns only when a frame ends on a transmit-clock edge.
    assert_ready_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(fall_p && busy));

endmodule

// File: tb/serial_tx_flow_tb.sv
module serial_tx_flow_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txc = 1'b1;
    logic       cts_n = 1'b1;
    logic       tx_en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = '0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b1;
    logic       txd;
    logic       tx_empty;
    logic       tx_ready;

    int n_checks = 0;
    int n_fails  = 0;
    int div      = 0;

    serial_tx_flow #(
        .DATA_W      (8),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .txc          (txc),
        .cts_n        (cts_n),
        .tx_en        (tx_en),
        .load         (load),
        .load_data    (load_data),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .txd          (txd),
        .tx_empty     (tx_empty),
        .tx_ready     (tx_ready)
    );

    // 250 MHz system clock
    always #2 clk = ~clk;

    // Transmit clock: 16 system cycles per period, toggled away from posedge
    always @(negedge clk) begin
        if (div == 7) begin
            div = 0;
            txc = ~txc;
        end else begin
            div = div + 1;
        end
    end

    // Table entries: {data, len, par_en, par_odd, two_stop}
    localparam logic [12:0] VEC [8] = '{
        {8'h55, 2'd3, 1'b0, 1'b0, 1'b1},
        {8'hAA, 2'd3, 1'b0, 1'b0, 1'b0},
        {8'h33, 2'd3, 1'b1, 1'b0, 1'b1},
        {8'h0D, 2'd0, 1'b1, 1'b1, 1'b0},
        {8'h48, 2'd1, 1'b0, 1'b0, 1'b0},
        {8'hE7, 2'd2, 1'b1, 1'b0, 1'b0},
        {8'hFF, 2'd3, 1'b1, 1'b1, 1'b1},
        {8'h00, 2'd0, 1'b1, 1'b0, 1'b1}
    };

    function automatic int exp_count(logic [1:0] len, logic pe, logic ts);
        return 2 + 5 + int'(len) + int'(pe) + int'(ts);
    endfunction

    function automatic logic [15:0] exp_frame(logic [7:0] d, logic [1:0] len,
                                              logic pe, logic po);
        logic [15:0] f;
        logic        ones;
        int          n;
        n = 5 + int'(len);
        f = '1;
        f[0] = 1'b0;
        ones = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[i+1] = d[i];
            ones = ones ^ d[i];
        end
        if (pe) f[n+1] = ones ^ po;
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic pe, input logic po,
                           input logic ts);
        @(negedge clk);
        cfg_len = len;
        cfg_par_en = pe;
        cfg_par_odd = po;
        cfg_two_stop = ts;
    endtask

    task automatic put_byte(input logic [7:0] d);
        @(negedge clk);
        load = 1'b1;
        load_data = d;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Sample txd on rising txc (mid-bit). With immediate set, the first
    // sample must already be the start bit.
    task automatic capture(input int nb, input bit immediate,
                           output logic [15:0] got, output bit seen,
                           output logic empty_at_start, output logic ready_at_start,
                           output logic ready_at_last);
        got = '1;
        seen = 1'b0;
        empty_at_start = 1'b0;
        ready_at_start = 1'b1;
        ready_at_last = 1'b1;
        if (immediate) begin
            @(posedge txc);
            seen = (txd == 1'b0);
        end else begin
            for (int k = 0; k < 60 && !seen; k++) begin
                @(posedge txc);
                if (txd == 1'b0) seen = 1'b1;
            end
        end
        if (seen) begin
            got[0] = 1'b0;
            empty_at_start = tx_empty;
            ready_at_start = tx_ready;
            for (int i = 1; i < nb; i++) begin
                @(posedge txc);
                got[i] = txd;
            end
            ready_at_last = tx_ready;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] got;
        logic [15:0] exp;
        bit          seen;
        logic        e0, r0, rl;
        int          nb;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(txd === 1'b1, "R1 idle line", 32'(txd), 1);
        check(tx_empty === 1'b1, "R1 empty after reset", 32'(tx_empty), 1);
        check(tx_ready === 1'b1, "R1 ready after reset", 32'(tx_ready), 1);

        tx_en = 1'b1;
        cts_n = 1'b0;

        // Table walk: R2, R3, R4 frame contents under several configurations
        for (int v = 0; v < 8; v++) begin
            set_cfg(VEC[v][4:3], VEC[v][2], VEC[v][1], VEC[v][0]);
            nb  = exp_count(VEC[v][4:3], VEC[v][2], VEC[v][0]);
            exp = exp_frame(VEC[v][12:5], VEC[v][4:3], VEC[v][2], VEC[v][1]);
            put_byte(VEC[v][12:5]);
            capture(nb, 1'b0, got, seen, e0, r0, rl);
            check(seen, "R2 start bit seen", 32'(seen), 1);
            check(got == exp, "R2 R3 R4 frame bits", 32'(got), 32'(exp));
            @(posedge txc);
            check(txd === 1'b1, "R4 line high after stop", 32'(txd), 1);
            check(tx_ready === 1'b1, "R9 ready after frame", 32'(tx_ready), 1);
        end

        // R6 and R8/R9: clear-to-send holds a pending byte
        set_cfg(2'd3, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        cts_n = 1'b1;
        repeat (40) @(negedge clk);
        put_byte(8'h55);
        for (int k = 0; k < 4; k++) begin
            @(posedge txc);
            check(txd === 1'b1, "R6 held while cts high", 32'(txd), 1);
        end
        check(tx_empty === 1'b0, "R8 empty low while pending", 32'(tx_empty), 0);
        check(tx_ready === 1'b0, "R9 ready low while pending", 32'(tx_ready), 0);
        @(negedge clk);
        cts_n = 1'b0;
        capture(11, 1'b0, got, seen, e0, r0, rl);
        exp = exp_frame(8'h55, 2'd3, 1'b0, 1'b0);
        check(seen && got == exp, "R6 frame after cts low", 32'(got), 32'(exp));
        check(e0 === 1'b1, "R8 empty at start bit", 32'(e0), 1);
        check(r0 === 1'b0, "R9 ready low at start bit", 32'(r0), 0);
        check(rl === 1'b0, "R9 ready low during last stop", 32'(rl), 0);
        @(posedge txc);
        check(tx_ready === 1'b1, "R9 ready after last stop", 32'(tx_ready), 1);

        // R7: disable holds a pending byte
        @(negedge clk);
        tx_en = 1'b0;
        put_byte(8'h3C);
        for (int k = 0; k < 3; k++) begin
            @(posedge txc);
            check(txd === 1'b1, "R7 held while disabled", 32'(txd), 1);
        end
        @(negedge clk);
        tx_en = 1'b1;
        capture(11, 1'b0, got, seen, e0, r0, rl);
        exp = exp_frame(8'h3C, 2'd3, 1'b0, 1'b0);
        check(seen && got == exp, "R7 frame after enable", 32'(got), 32'(exp));
        @(posedge txc);

        // R10: second load while occupied is ignored
        @(negedge clk);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        put_byte(8'h0F);
        put_byte(8'hF0);
        @(negedge clk);
        cts_n = 1'b0;
        capture(11, 1'b0, got, seen, e0, r0, rl);
        exp = exp_frame(8'h0F, 2'd3, 1'b0, 1'b0);
        check(seen && got == exp, "R10 held byte kept", 32'(got), 32'(exp));
        @(posedge txc);
        check(txd === 1'b1, "R10 no second frame", 32'(txd), 1);

        // R11: back-to-back frames with no idle bit
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        put_byte(8'h0A);
        for (int k = 0; k < 200 && tx_empty !== 1'b1; k++) @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 200 && tx_empty !== 1'b1; k++) @(negedge clk);
        put_byte(8'h0D);
        capture(10, 1'b0, got, seen, e0, r0, rl);
        exp = exp_frame(8'h0A, 2'd3, 1'b0, 1'b0);
        check(seen && got == exp, "R11 first frame", 32'(got), 32'(exp));
        check(rl === 1'b0, "R9 ready low with byte queued", 32'(rl), 0);
        capture(10, 1'b1, got, seen, e0, r0, rl);
        exp = exp_frame(8'h0D, 2'd3, 1'b0, 1'b0);
        check(seen, "R11 start follows stop directly", 32'(seen), 1);
        check(got == exp, "R11 second frame", 32'(got), 32'(exp));
        @(posedge txc);
        check(txd === 1'b1, "R1 idle after frames", 32'(txd), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule